// File: doc/BRIEF.md
# Serial Flash Command Frame Decoder

This block sits on the target side of a single-lane serial flash interface. It watches bits shifted in while chip select is low and treats the first complete byte of each frame as an opcode. From that opcode and the current modes, it works out the rest of the frame: how many address bytes follow, how many dummy bit periods are skipped, and whether a data phase starts. Downstream array and one-time-programmable storage logic receives the accepted opcode, the assembled address, a data-phase start strobe and the program data bytes.

The serial pins are assumed to be synchronised into the system clock domain already. One bit is presented on `bit_in` with a single-cycle `bit_stb`, most significant bit first. Successive strobes are at least two clock cycles apart. The block keeps three pieces of state: the address width (three or four bytes), the deep power-down mode, and a write-enable latch. Every change to this state is committed on the clock after chip select is seen rising, so a frame that is cut short leaves all three unchanged.

Top module: `spi_cmd_decoder`

## Requirements
- R1: After synchronous reset, `addr4`, `pd`, `wel` and `prog_ovf` are 0, and no strobe output (`cmd_vld`, `illegal`, `addr_vld`, `data_go`, `wr_vld`) is asserted.
- R2: The first eight bits of a frame form the opcode, MSB first. For an accepted opcode (06h, B7h, E9h, B9h, ABh, 4Bh, and 42h with the latch set), `cmd_vld` pulses once with the code on `cmd_op`. At most one of `cmd_vld`, `addr_vld`, `wr_vld`, `illegal` is high in any cycle.
- R3: Opcode B7h selects four-byte addressing and E9h selects three-byte addressing. Neither takes address or dummy bits. The mode (`addr4`) changes only when chip select rises after the opcode, and no mode output changes while chip select is low.
- R4: Opcode B9h sets `pd` and ABh clears it, both at chip-select rise. While `pd` is 1, every opcode except ABh is ignored: no strobes and no mode change for that frame.
- R5: Opcode 4Bh (OTP read) is followed by three address bytes, or four when `addr4` is 1, MSB first. `addr_vld` pulses once after the last one, with the address right-aligned on `addr_q` and the unused upper byte zero.
- R6: After the OTP read address, the decoder counts dummy bit strobes. The count is `dummy_cfg` when that is nonzero, otherwise 8, or 10 when `quad_en` is 1. `data_go` pulses in the cycle after the last dummy strobe is registered, and not before.
- R7: Opcode 42h (OTP program) is accepted only when `wel` is 1. Without the latch the frame produces no strobe at all, and `wr_vld` is never high while `wel` is 0.
- R8: In an accepted program frame, `data_go` pulses together with `addr_vld`, and the following bytes appear on `wr_byte`/`wr_vld`, up to 64 of them. Further bytes are dropped and set `prog_ovf`, which holds until the next frame's opcode byte.
- R9: Opcode 06h sets `wel` at chip-select rise. A program frame that reached its data phase clears `wel` at its chip-select rise.
- R10: A frame whose chip select rises during the address or dummy phase produces no `data_go` and changes no mode or latch.
- R11: An opcode not listed in R2 pulses `illegal` once and produces no further strobe for that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low, synchronised |
| bit_stb | input | 1 | One-cycle strobe marking a valid serial bit |
| bit_in | input | 1 | Serial data bit, MSB first |
| quad_en | input | 1 | Static quad-protocol enable, affects the default dummy count only |
| dummy_cfg | input | DUMMY_W | Configured dummy count for OTP read, 0 selects the default |
| cmd_op | output | 8 | Last accepted opcode |
| cmd_vld | output | 1 | Pulse: opcode accepted |
| illegal | output | 1 | Pulse: unknown opcode |
| addr_q | output | ADDR_W | Assembled address |
| addr_vld | output | 1 | Pulse: address complete |
| data_go | output | 1 | Pulse: data phase begins |
| wr_byte | output | 8 | Program data byte |
| wr_vld | output | 1 | Pulse: program byte valid |
| prog_ovf | output | 1 | Program byte limit exceeded in this frame |
| addr4 | output | 1 | Four-byte address mode active |
| pd | output | 1 | Deep power-down active |
| wel | output | 1 | Write-enable latch |

## Verification
The hardest state to reach is the program-frame overflow. It needs the latch set by an earlier frame, an address of the current width, and then more than 64 data bytes, all in one frame with chip select held low. The stimulus runs a write-enable frame first, then an aborted program frame to show that the latch survives an abort. It then sends 66 bytes in one frame and checks the byte count, the last accepted byte and the overflow flag on either side of the 64th byte. Power-down filtering is reached the same way: a deep power-down frame is followed by write-enable and read frames that must produce nothing.

// File: rtl/spi_dec_pkg.sv
package spi_dec_pkg;
  localparam logic [7:0] OP_WREN  = 8'h06;
  localparam logic [7:0] OP_EN4   = 8'hB7;
  localparam logic [7:0] OP_EX4   = 8'hE9;
  localparam logic [7:0] OP_PDN   = 8'hB9;
  localparam logic [7:0] OP_REL   = 8'hAB;
  localparam logic [7:0] OP_OTPRD = 8'h4B;
  localparam logic [7:0] OP_OTPWR = 8'h42;

  typedef enum logic [2:0] {ST_OP, ST_ADDR, ST_DUMMY, ST_DATA, ST_SKIP} phase_t;

  // action committed at chip-select rise
  typedef enum logic [2:0] {PM_NONE, PM_EN4, PM_EX4, PM_PDN, PM_REL, PM_WREN, PM_WCLR} pend_t;
endpackage

// File: rtl/spi_byte_shift.sv
module spi_byte_shift #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              frame_on,
  input  logic              bit_stb,
  input  logic              bit_in,
  output logic              byte_vld,
  output logic [BYTE_W-1:0] byte_q
);
  localparam int CW = $clog2(BYTE_W);

  logic [CW-1:0]     cnt;
  logic [BYTE_W-2:0] sh;

  always_ff @(posedge clk) begin
    if (rst || !frame_on) begin
      cnt      <= '0;
      byte_vld <= 1'b0;
      if (rst) begin
        sh     <= '0;
        byte_q <= '0;
      end
    end else begin
      byte_vld <= 1'b0;
      if (bit_stb) begin
        sh  <= {sh[BYTE_W-3:0], bit_in};
        cnt <= cnt + 1'b1;
        if (cnt == CW'(BYTE_W - 1)) begin
          byte_vld <= 1'b1;
          byte_q   <= {sh, bit_in};
        end
      end
    end
  end
endmodule

// File: rtl/spi_mode_regs.sv
module spi_mode_regs
  import spi_dec_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  apply,
  input  pend_t pend,
  output logic  addr4,
  output logic  pd,
  output logic  wel
);
  always_ff @(posedge clk) begin
    if (rst) begin
      addr4 <= 1'b0;
      pd    <= 1'b0;
      wel   <= 1'b0;
    end else if (apply) begin
      case (pend)
        PM_EN4:  addr4 <= 1'b1;
        PM_EX4:  addr4 <= 1'b0;
        PM_PDN:  pd    <= 1'b1;
        PM_REL:  pd    <= 1'b0;
        PM_WREN: wel   <= 1'b1;
        PM_WCLR: wel   <= 1'b0;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/spi_cmd_decoder.sv
module spi_cmd_decoder
  import spi_dec_pkg::*;
#(
  parameter int DUMMY_W        = 4,
  parameter int ADDR_W         = 32,
  parameter int MAX_PROG       = 64,
  parameter int DEF_DUMMY      = 8,
  parameter int DEF_DUMMY_QUAD = 10
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cs_n,
  input  logic               bit_stb,
  input  logic               bit_in,
  input  logic               quad_en,
  input  logic [DUMMY_W-1:0] dummy_cfg,
  output logic [7:0]         cmd_op,
  output logic               cmd_vld,
  output logic               illegal,
  output logic [ADDR_W-1:0]  addr_q,
  output logic               addr_vld,
  output logic               data_go,
  output logic [7:0]         wr_byte,
  output logic               wr_vld,
  output logic               prog_ovf,
  output logic               addr4,
  output logic               pd,
  output logic               wel
);
  localparam int CNT_W = $clog2(MAX_PROG + 1);
  localparam int DN_W  = (DUMMY_W > 4) ? DUMMY_W : 4;

  logic             byte_vld;
  logic [7:0]       byte_q;
  logic             cs_q;
  phase_t           st;
  pend_t            pend;
  logic             is_rd;
  logic [2:0]       acnt;
  logic [2:0]       need;
  logic [DN_W-1:0]  dcnt;
  logic [DN_W-1:0]  dummy_n;
  logic [CNT_W-1:0] wcnt;

  spi_byte_shift #(.BYTE_W(8)) u_shift (
    .clk      (clk),
    .rst      (rst),
    .frame_on (!cs_n),
    .bit_stb  (bit_stb),
    .bit_in   (bit_in),
    .byte_vld (byte_vld),
    .byte_q   (byte_q)
  );

  spi_mode_regs u_modes (
    .clk   (clk),
    .rst   (rst),
    .apply (cs_n && !cs_q),
    .pend  (pend),
    .addr4 (addr4),
    .pd    (pd),
    .wel   (wel)
  );

  always_comb begin
    need = addr4 ? 3'd4 : 3'd3;
    if (dummy_cfg != '0)
      dummy_n = DN_W'(dummy_cfg);
    else if (quad_en)
      dummy_n = DN_W'(DEF_DUMMY_QUAD);
    else
      dummy_n = DN_W'(DEF_DUMMY);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_q     <= 1'b1;
      st       <= ST_OP;
      pend     <= PM_NONE;
      is_rd    <= 1'b0;
      acnt     <= '0;
      dcnt     <= '0;
      wcnt     <= '0;
      cmd_op   <= '0;
      cmd_vld  <= 1'b0;
      illegal  <= 1'b0;
      addr_q   <= '0;
      addr_vld <= 1'b0;
      data_go  <= 1'b0;
      wr_byte  <= '0;
      wr_vld   <= 1'b0;
      prog_ovf <= 1'b0;
    end else begin
      cs_q     <= cs_n;
      cmd_vld  <= 1'b0;
      illegal  <= 1'b0;
      addr_vld <= 1'b0;
      data_go  <= 1'b0;
      wr_vld   <= 1'b0;
      if (cs_n) begin
        st   <= ST_OP;
        pend <= PM_NONE;
      end else begin
        case (st)
          ST_OP: if (byte_vld) begin
            prog_ovf <= 1'b0;
            addr_q   <= '0;
            acnt     <= '0;
            dcnt     <= '0;
            wcnt     <= '0;
            st       <= ST_SKIP;
            if (pd) begin
              if (byte_q == OP_REL) begin
                cmd_vld <= 1'b1;
                cmd_op  <= byte_q;
                pend    <= PM_REL;
              end
            end else begin
              case (byte_q)
                OP_EN4, OP_EX4, OP_PDN, OP_REL, OP_WREN: begin
                  cmd_vld <= 1'b1;
                  cmd_op  <= byte_q;
                  case (byte_q)
                    OP_EN4:  pend <= PM_EN4;
                    OP_EX4:  pend <= PM_EX4;
                    OP_PDN:  pend <= PM_PDN;
                    OP_WREN: pend <= PM_WREN;
                    default: pend <= PM_NONE;
                  endcase
                end
                OP_OTPRD: begin
                  cmd_vld <= 1'b1;
                  cmd_op  <= byte_q;
                  is_rd   <= 1'b1;
                  st      <= ST_ADDR;
                end
                OP_OTPWR: if (wel) begin
                  cmd_vld <= 1'b1;
                  cmd_op  <= byte_q;
                  is_rd   <= 1'b0;
                  st      <= ST_ADDR;
                end
                default: illegal <= 1'b1;
              endcase
            end
          end
          ST_ADDR: if (byte_vld) begin
            addr_q <= {addr_q[ADDR_W-9:0], byte_q};
            acnt   <= acnt + 3'd1;
            if (acnt == need - 3'd1) begin
              addr_vld <= 1'b1;
              if (is_rd) begin
                st <= ST_DUMMY;
              end else begin
                data_go <= 1'b1;
                pend    <= PM_WCLR;
                st      <= ST_DATA;
              end
            end
          end
          ST_DUMMY: if (bit_stb) begin
            dcnt <= dcnt + 1'b1;
            if (dcnt == dummy_n - DN_W'(1)) begin
              data_go <= 1'b1;
              st      <= ST_SKIP;
            end
          end
          ST_DATA: if (byte_vld) begin
            if (wcnt < CNT_W'(MAX_PROG)) begin
              wr_vld  <= 1'b1;
              wr_byte <= byte_q;
              wcnt    <= wcnt + 1'b1;
            end else begin
              prog_ovf <= 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/spi_cmd_decoder_chk.sv
module spi_cmd_decoder_chk #(
  parameter int MAX_PROG = 64
) (
  input logic clk,
  input logic rst,
  input logic cs_n,
  input logic cmd_vld,
  input logic illegal,
  input logic addr_vld,
  input logic data_go,
  input logic wr_vld,
  input logic addr4,
  input logic pd,
  input logic wel
);
  localparam int KW = $clog2(MAX_PROG + 2) + 1;
  logic [KW-1:0] wr_seen;

  always_ff @(posedge clk) begin
    if (rst || cs_n) wr_seen <= '0;
    else if (wr_vld) wr_seen <= wr_seen + 1'b1;
  end

  assert_strobe_excl_R2: assert property (@(posedge clk) disable iff (rst)
    $onehot0({cmd_vld, addr_vld, wr_vld, illegal}));

  assert_mode_hold_R3: assert property (@(posedge clk) disable iff (rst)
    !cs_n |=> ($stable(addr4) && $stable(pd) && $stable(wel)));

  assert_pd_quiet_R4: assert property (@(posedge clk) disable iff (rst)
    pd |-> !(addr_vld || data_go || wr_vld || illegal));

  assert_prog_needs_wel_R7: assert property (@(posedge clk) disable iff (rst)
    wr_vld |-> wel);

  assert_prog_limit_R8: assert property (@(posedge clk) disable iff (rst)
    wr_seen <= KW'(MAX_PROG));
endmodule

bind spi_cmd_decoder spi_cmd_decoder_chk #(.MAX_PROG(MAX_PROG)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .cs_n     (cs_n),
  .cmd_vld  (cmd_vld),
  .illegal  (illegal),
  .addr_vld (addr_vld),
  .data_go  (data_go),
  .wr_vld   (wr_vld),
  .addr4    (addr4),
  .pd       (pd),
  .wel      (wel)
);

// File: tb/spi_cmd_decoder_bench.sv
module spi_cmd_decoder_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cs_n = 1'b1;
  logic        bit_stb = 1'b0;
  logic        bit_in = 1'b0;
  logic        quad_en = 1'b0;
  logic [3:0]  dummy_cfg = 4'd0;
  logic [7:0]  cmd_op;
  logic        cmd_vld, illegal, addr_vld, data_go, wr_vld, prog_ovf;
  logic        addr4, pd, wel;
  logic [31:0] addr_q;
  logic [7:0]  wr_byte;

  int n_checks = 0;
  int n_err    = 0;
  bit finished = 1'b0;

  int n_cmd = 0, n_ill = 0, n_addr = 0, n_go = 0, n_wr = 0;
  int b_cmd, b_ill, b_addr, b_go, b_wr;
  logic [7:0]  last_op = 8'h00;
  logic [31:0] last_addr = 32'h0;
  logic [7:0]  last_wr = 8'h00;

  always #2 clk = ~clk;

  spi_cmd_decoder u_spi_cmd_decoder (
    .clk(clk), .rst(rst), .cs_n(cs_n), .bit_stb(bit_stb), .bit_in(bit_in),
    .quad_en(quad_en), .dummy_cfg(dummy_cfg), .cmd_op(cmd_op), .cmd_vld(cmd_vld),
    .illegal(illegal), .addr_q(addr_q), .addr_vld(addr_vld), .data_go(data_go),
    .wr_byte(wr_byte), .wr_vld(wr_vld), .prog_ovf(prog_ovf), .addr4(addr4),
    .pd(pd), .wel(wel)
  );

  always @(negedge clk) begin
    if (cmd_vld)  begin n_cmd++;  last_op = cmd_op; end
    if (illegal)  n_ill++;
    if (addr_vld) begin n_addr++; last_addr = addr_q; end
    if (data_go)  n_go++;
    if (wr_vld)   begin n_wr++;   last_wr = wr_byte; end
  end

  // opcode, expected cmd_vld, expected illegal
  localparam logic [9:0] VEC [8] = '{
    {8'hAB, 1'b1, 1'b0}, {8'h00, 1'b0, 1'b1}, {8'hFF, 1'b0, 1'b1},
    {8'h03, 1'b0, 1'b1}, {8'h42, 1'b0, 1'b0}, {8'h4B, 1'b1, 1'b0},
    {8'h9F, 1'b0, 1'b1}, {8'hE9, 1'b1, 1'b0}
  };

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic mark();
    b_cmd = n_cmd; b_ill = n_ill; b_addr = n_addr; b_go = n_go; b_wr = n_wr;
  endtask

  task automatic send_bit(input logic b);
    @(negedge clk); bit_in = b; bit_stb = 1'b1;
    @(negedge clk); bit_stb = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic send_byte(input logic [7:0] v);
    for (int k = 7; k >= 0; k--) send_bit(v[k]);
  endtask

  task automatic cs_start();
    @(negedge clk); cs_n = 1'b0;
    repeat (2) @(negedge clk);
    mark();
  endtask

  task automatic cs_end();
    @(negedge clk); cs_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic otp_read(input logic [31:0] a, input int nbytes, input int ndum, input string tag);
    cs_start();
    send_byte(8'h4B);
    for (int k = nbytes - 1; k >= 0; k--) begin
      if (k == 0) chk(tag, "addr_vld before last byte", n_addr - b_addr, 0);
      send_byte(a[8*k +: 8]);
    end
    chk(tag, "addr_vld count", n_addr - b_addr, 1);
    chk(tag, "address", last_addr, a);
    for (int k = 0; k < ndum - 1; k++) send_bit(1'b0);
    chk(tag, "data_go early", n_go - b_go, 0);
    send_bit(1'b0);
    chk(tag, "data_go after dummies", n_go - b_go, 1);
    cs_end();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1", "addr4", addr4, 0);
    chk("R1", "pd", pd, 0);
    chk("R1", "wel", wel, 0);
    chk("R1", "prog_ovf", prog_ovf, 0);
    chk("R1", "strobes", {cmd_vld, illegal, addr_vld, data_go, wr_vld}, 0);

    // R2, R7, R11 opcode table walk
    for (int i = 0; i < 8; i++) begin
      cs_start();
      send_byte(VEC[i][9:2]);
      cs_end();
      chk("R2", "cmd_vld count", n_cmd - b_cmd, VEC[i][1]);
      chk("R11", "illegal count", n_ill - b_ill, VEC[i][0]);
      chk("R7", "no data_go", n_go - b_go, 0);
      if (VEC[i][1]) chk("R2", "cmd_op", last_op, VEC[i][9:2]);
    end
    chk("R7", "wel after rejected program", wel, 0);

    // R5, R6 read with defaults, quad default, configured count
    otp_read(32'h0012_3456, 3, 8, "R6");
    quad_en = 1'b1;
    otp_read(32'h00AB_CDEF, 3, 10, "R6");
    dummy_cfg = 4'd3;
    otp_read(32'h0001_0203, 3, 3, "R6");
    quad_en = 1'b0;
    dummy_cfg = 4'd0;

    // R3 four-byte mode
    cs_start();
    send_byte(8'hB7);
    chk("R3", "addr4 before cs rise", addr4, 0);
    cs_end();
    chk("R3", "addr4 after B7", addr4, 1);
    otp_read(32'hA1B2_C3D4, 4, 8, "R5");
    cs_start();
    send_byte(8'hE9);
    cs_end();
    chk("R3", "addr4 after E9", addr4, 0);

    // R10 read aborted in dummy phase
    cs_start();
    send_byte(8'h4B);
    send_byte(8'h00); send_byte(8'h00); send_byte(8'h10);
    send_bit(1'b0); send_bit(1'b0);
    cs_end();
    chk("R10", "no data_go on abort", n_go - b_go, 0);

    // R9 write enable
    cs_start();
    send_byte(8'h06);
    chk("R9", "wel before cs rise", wel, 0);
    cs_end();
    chk("R9", "wel set", wel, 1);

    // R10 program aborted in address phase
    cs_start();
    send_byte(8'h42);
    chk("R2", "program accepted", n_cmd - b_cmd, 1);
    send_byte(8'h00); send_byte(8'h01);
    cs_end();
    chk("R10", "wel kept after abort", wel, 1);
    chk("R10", "no data_go", n_go - b_go, 0);

    // R8 program with overflow
    cs_start();
    send_byte(8'h42);
    send_byte(8'h00); send_byte(8'h01); send_byte(8'h00);
    chk("R8", "data_go with address", n_go - b_go, 1);
    chk("R8", "address", last_addr, 32'h0000_0100);
    for (int i = 0; i < 66; i++) begin
      send_byte(8'(8'h10 + i));
      if (i == 63) chk("R8", "ovf at limit", prog_ovf, 0);
      if (i == 64) chk("R8", "ovf past limit", prog_ovf, 1);
    end
    chk("R8", "bytes delivered", n_wr - b_wr, 64);
    chk("R8", "last byte", last_wr, 8'h4F);
    chk("R9", "wel held during frame", wel, 1);
    cs_end();
    chk("R9", "wel cleared", wel, 0);
    chk("R8", "ovf held after frame", prog_ovf, 1);
    cs_start();
    send_byte(8'hE9);
    chk("R8", "ovf cleared by opcode", prog_ovf, 0);
    cs_end();

    // R4 deep power-down
    cs_start();
    send_byte(8'hB9);
    chk("R4", "pd before cs rise", pd, 0);
    cs_end();
    chk("R4", "pd set", pd, 1);
    cs_start();
    send_byte(8'h06);
    cs_end();
    chk("R4", "write enable ignored", wel, 0);
    chk("R4", "no cmd in pd", n_cmd - b_cmd, 0);
    cs_start();
    send_byte(8'h4B);
    send_byte(8'h00); send_byte(8'h00); send_byte(8'h00);
    cs_end();
    chk("R4", "no addr in pd", n_addr - b_addr, 0);
    chk("R4", "no illegal in pd", n_ill - b_ill, 0);
    cs_start();
    send_byte(8'hAB);
    cs_end();
    chk("R4", "release cmd", n_cmd - b_cmd, 1);
    chk("R4", "release op", last_op, 8'hAB);
    chk("R4", "pd cleared", pd, 0);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end
endmodule